// File: doc/BRIEF.md
# Local Interrupt Controller Register Bank

This block holds the software-visible 32-bit registers of one processor's local interrupt controller. A 4 KB window starting at 0xFEE00000 maps these registers, and the block is reached at word offsets inside that window. Each bus request carries an offset, a write flag, a byte length and write data. The block decodes the offset and applies the access class of the register it selects. It then returns a registered response one cycle later, made of valid, error and read data.

Nothing in the bank changes on an illegal access, and the response carries the error flag. The stored configuration drives output ports for the neighbouring timer and interrupt-tracking logic:
- the local vector entries
- the timer counts and divider
- the 256-bit enable mask
- the task priority, the ID and the spurious vector

The neighbours supply the request, in-service and trigger-mode bit arrays, which the bank only reads. A separate base-register write port sets or clears the bootstrap flag and the global enable flag. The base address itself is fixed.

Top module: `lic_regbank`

## Requirements
- R1: After reset, base_msr reads 0x00000000FEE00900, which means bootstrap (bit 8) and enable (bit 11) are both set. The reset values are: ID 0, version 0x80050010, destination format 0xFFFFFFFF, spurious 0x000000FF, every one of the six local vector entries 0x00010000, the enable mask all ones, and every other stored register 0.
- R2: rsp_valid is high in exactly the cycle after a cycle with req_valid high. Read data is returned in that cycle. A write is visible to a read issued in the next cycle.
- R3: A request whose req_len is not 4 gets rsp_err=1 and changes no register.
- R4: While bit 11 of base_msr is 0, every request gets rsp_err=1. A base-register write changes only bits 8 and 11.
- R5: These registers are read-only: a write to any of them gets rsp_err=1 and changes nothing. They are version 0x030, arbitration priority 0x090, processor priority 0x0A0, remote read 0x0C0, interrupt command 0x300/0x310, the in-service, trigger and request arrays, and feature 0x400. Arbitration priority, processor priority, remote read and interrupt command all read as 0.
- R6: Any access to 0x0B0 gets an error, and so does any access to 0x400, 0x410, 0x420 or 0x500–0x530. Any access to an undecoded or unaligned offset also gets an error. Every error response carries rsp_rdata=0.
- R7: These registers read back exactly what was last written: ID 0x020, task priority 0x080, logical destination 0x0D0, destination format 0x0E0, spurious 0x0F0, error status 0x280 and divider 0x3E0. The six local vector entries also read back their last write. They sit at 0x320 + 0x10·k and appear in lvt_flat bits [32k+31:32k], for k=0 timer, 1 thermal, 2 perf, 3 lint0, 4 lint1, 5 error.
- R8: A read of word k (0..7) of an array returns that array's input bits [32k+31:32k]. The in-service array starts at 0x100, the trigger array at 0x180 and the request array at 0x200, each with a 0x10 stride.
- R9: The enable mask is read-write at 0x480 + 0x10·k. Word k drives irq_enable[32k+31:32k].
- R10: A write to 0x380 loads both the initial count (tmr_init) and the current count (tmr_cur). A write to 0x390 loads only tmr_cur, and 0x390 reads back tmr_cur.
- R11: A bus request and a base-register write may fall in the same cycle. In that case the request is judged against the enable flag as it stood before that clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte offset inside the 4 KB window |
| req_len | input | 3 | Access length in bytes |
| req_wdata | input | 32 | Write data |
| base_wr | input | 1 | Base-register write strobe |
| base_wr_boot | input | 1 | New bootstrap flag |
| base_wr_en | input | 1 | New global enable flag |
| isr_in | input | 256 | In-service bits from the tracking logic |
| trig_in | input | 256 | Trigger-mode bits from the tracking logic |
| irr_in | input | 256 | Request bits from the tracking logic |
| rsp_valid | output | 1 | Response for last cycle's request |
| rsp_err | output | 1 | Response is an error |
| rsp_rdata | output | 32 | Read data (0 on error or write) |
| base_msr | output | 64 | Base/enable register value |
| local_id | output | 32 | ID register |
| task_prio | output | 32 | Task priority register |
| spurious | output | 32 | Spurious vector register |
| lvt_flat | output | 192 | Six local vector entries, entry k at bits [32k+31:32k] |
| tmr_init | output | 32 | Timer initial count |
| tmr_cur | output | 32 | Timer current count |
| tmr_div | output | 32 | Timer divide configuration |
| irq_enable | output | 256 | Interrupt enable mask |

## Verification
Two things can meet at the same clock edge: a bus request, and a base-register write that flips the global enable. The bench drives both in one cycle, first clearing the enable flag and then setting it again.

When the flag is being cleared, the request must still succeed, because the flag was set before the edge. The following request must then fail. When the flag is being set again, the request in the same cycle must fail, and the request after it must succeed again.

// File: rtl/lic_pkg.sv
// Shared constants and types for the local interrupt controller register bank.
// Assumes a 12-bit byte offset and 32-bit registers at 16-byte alignment.
package lic_pkg;
    localparam int ADDR_W  = 12;
    localparam int DATA_W  = 32;
    localparam int NUM_VEC = 256;
    localparam int WORDS   = NUM_VEC / DATA_W;
    localparam int IDX_W   = $clog2(WORDS);
    localparam int LVT_N   = 6;

    localparam logic [DATA_W-1:0] WIN_BASE = 32'hFEE0_0000;
    localparam logic [DATA_W-1:0] RST_VER  = 32'h8005_0010;
    localparam logic [DATA_W-1:0] RST_DFR  = 32'hFFFF_FFFF;
    localparam logic [DATA_W-1:0] RST_SPUR = 32'h0000_00FF;
    localparam logic [DATA_W-1:0] RST_LVT  = 32'h0001_0000;

    typedef enum logic [4:0] {
        SEL_NONE, SEL_ID, SEL_VER, SEL_TPR, SEL_APR, SEL_PPR, SEL_EOI,
        SEL_RRD, SEL_LDR, SEL_DFR, SEL_SPUR, SEL_ISR, SEL_TRG, SEL_IRR,
        SEL_ESR, SEL_ICMD, SEL_LVT, SEL_TINIT, SEL_TCUR, SEL_TDIV,
        SEL_FEAT, SEL_UNH, SEL_IEN
    } sel_e;
endpackage

// File: rtl/lic_decode.sv
// Offset decoder: maps a byte offset to a register select, a word or entry
// index and the read/write permissions. Assumes nothing about the request.
module lic_decode
    import lic_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output sel_e              sel,
    output logic [IDX_W-1:0]  idx,
    output logic              rd_ok,
    output logic              wr_ok
);
    logic [7:0] slot;
    assign slot = addr[ADDR_W-1:4];

    // Classify the offset; unaligned offsets stay undecoded.
    always_comb begin
        sel   = SEL_NONE;
        idx   = addr[4 +: IDX_W];
        rd_ok = 1'b0;
        wr_ok = 1'b0;
        if (addr[3:0] == 4'h0) begin
            case (slot) inside
                8'h02:          begin sel = SEL_ID;    rd_ok = 1'b1; wr_ok = 1'b1; end
                8'h03:          begin sel = SEL_VER;   rd_ok = 1'b1; end
                8'h08:          begin sel = SEL_TPR;   rd_ok = 1'b1; wr_ok = 1'b1; end
                8'h09:          begin sel = SEL_APR;   rd_ok = 1'b1; end
                8'h0A:          begin sel = SEL_PPR;   rd_ok = 1'b1; end
                8'h0B:          begin sel = SEL_EOI; end
                8'h0C:          begin sel = SEL_RRD;   rd_ok = 1'b1; end
                8'h0D:          begin sel = SEL_LDR;   rd_ok = 1'b1; wr_ok = 1'b1; end
                8'h0E:          begin sel = SEL_DFR;   rd_ok = 1'b1; wr_ok = 1'b1; end
                8'h0F:          begin sel = SEL_SPUR;  rd_ok = 1'b1; wr_ok = 1'b1; end
                [8'h10:8'h17]:  begin sel = SEL_ISR;   rd_ok = 1'b1; end
                [8'h18:8'h1F]:  begin sel = SEL_TRG;   rd_ok = 1'b1; end
                [8'h20:8'h27]:  begin sel = SEL_IRR;   rd_ok = 1'b1; end
                8'h28:          begin sel = SEL_ESR;   rd_ok = 1'b1; wr_ok = 1'b1; end
                8'h30, 8'h31:   begin sel = SEL_ICMD;  rd_ok = 1'b1; end
                [8'h32:8'h37]:  begin sel = SEL_LVT;   rd_ok = 1'b1; wr_ok = 1'b1;
                                      idx = addr[4 +: IDX_W] - IDX_W'(2); end
                8'h38:          begin sel = SEL_TINIT; rd_ok = 1'b1; wr_ok = 1'b1; end
                8'h39:          begin sel = SEL_TCUR;  rd_ok = 1'b1; wr_ok = 1'b1; end
                8'h3E:          begin sel = SEL_TDIV;  rd_ok = 1'b1; wr_ok = 1'b1; end
                8'h40:          begin sel = SEL_FEAT; end
                8'h41, 8'h42:   begin sel = SEL_UNH; end
                [8'h48:8'h4F]:  begin sel = SEL_IEN;   rd_ok = 1'b1; wr_ok = 1'b1; end
                [8'h50:8'h53]:  begin sel = SEL_UNH; end
                default:        begin sel = SEL_NONE; end
            endcase
        end
    end
endmodule

// File: rtl/lic_store.sv
// Register storage: holds every writable register and the base/enable flags.
// Assumes wr_fire is already qualified by length, enable and permission.
module lic_store
    import lic_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_fire,
    input  sel_e                    sel,
    input  logic [IDX_W-1:0]        idx,
    input  logic [DATA_W-1:0]       wdata,
    input  logic                    base_wr,
    input  logic                    base_wr_boot,
    input  logic                    base_wr_en,
    output logic                    boot_q,
    output logic                    en_q,
    output logic [DATA_W-1:0]       id_q,
    output logic [DATA_W-1:0]       tpr_q,
    output logic [DATA_W-1:0]       ldr_q,
    output logic [DATA_W-1:0]       dfr_q,
    output logic [DATA_W-1:0]       spur_q,
    output logic [DATA_W-1:0]       esr_q,
    output logic [DATA_W-1:0]       tinit_q,
    output logic [DATA_W-1:0]       tcur_q,
    output logic [DATA_W-1:0]       tdiv_q,
    output logic [LVT_N*DATA_W-1:0] lvt_q,
    output logic [NUM_VEC-1:0]      ien_q
);
    // Base/enable flags: only bootstrap and enable are stored.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            boot_q <= 1'b1;
            en_q   <= 1'b1;
        end else if (base_wr) begin
            boot_q <= base_wr_boot;
            en_q   <= base_wr_en;
        end
    end

    // Scalar read-write registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            id_q   <= '0;
            tpr_q  <= '0;
            ldr_q  <= '0;
            dfr_q  <= RST_DFR;
            spur_q <= RST_SPUR;
            esr_q  <= '0;
            tdiv_q <= '0;
        end else if (wr_fire) begin
            case (sel)
                SEL_ID:   id_q   <= wdata;
                SEL_TPR:  tpr_q  <= wdata;
                SEL_LDR:  ldr_q  <= wdata;
                SEL_DFR:  dfr_q  <= wdata;
                SEL_SPUR: spur_q <= wdata;
                SEL_ESR:  esr_q  <= wdata;
                SEL_TDIV: tdiv_q <= wdata;
                default:  ;
            endcase
        end
    end

    // Timer counts: an initial-count write also reloads the current count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tinit_q <= '0;
            tcur_q  <= '0;
        end else if (wr_fire && sel == SEL_TINIT) begin
            tinit_q <= wdata;
            tcur_q  <= wdata;
        end else if (wr_fire && sel == SEL_TCUR) begin
            tcur_q  <= wdata;
        end
    end

    // One register per local vector entry.
    for (genvar k = 0; k < LVT_N; k++) begin : g_lvt
        always_ff @(posedge clk) begin
            if (!rst_n)
                lvt_q[k*DATA_W +: DATA_W] <= RST_LVT;
            else if (wr_fire && sel == SEL_LVT && idx == IDX_W'(k))
                lvt_q[k*DATA_W +: DATA_W] <= wdata;
        end
    end

    // One register per enable-mask word.
    for (genvar w = 0; w < WORDS; w++) begin : g_ien
        always_ff @(posedge clk) begin
            if (!rst_n)
                ien_q[w*DATA_W +: DATA_W] <= '1;
            else if (wr_fire && sel == SEL_IEN && idx == IDX_W'(w))
                ien_q[w*DATA_W +: DATA_W] <= wdata;
        end
    end

    // R10: an initial-count write shows up in the current count.
    a_r10_init_loads_cur: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_fire && sel == SEL_TINIT) |=> (tcur_q == $past(wdata) && tinit_q == $past(wdata)));
endmodule

// File: rtl/lic_rdmux.sv
// Read-data selector: picks the word for the decoded register.
// Assumes the caller zeroes the data on error.
module lic_rdmux
    import lic_pkg::*;
(
    input  sel_e                    sel,
    input  logic [IDX_W-1:0]        idx,
    input  logic                    boot_q,
    input  logic                    en_q,
    input  logic [DATA_W-1:0]       id_q,
    input  logic [DATA_W-1:0]       tpr_q,
    input  logic [DATA_W-1:0]       ldr_q,
    input  logic [DATA_W-1:0]       dfr_q,
    input  logic [DATA_W-1:0]       spur_q,
    input  logic [DATA_W-1:0]       esr_q,
    input  logic [DATA_W-1:0]       tinit_q,
    input  logic [DATA_W-1:0]       tcur_q,
    input  logic [DATA_W-1:0]       tdiv_q,
    input  logic [LVT_N*DATA_W-1:0] lvt_q,
    input  logic [NUM_VEC-1:0]      ien_q,
    input  logic [NUM_VEC-1:0]      isr_in,
    input  logic [NUM_VEC-1:0]      trig_in,
    input  logic [NUM_VEC-1:0]      irr_in,
    output logic [DATA_W-1:0]       rd_data,
    output logic [2*DATA_W-1:0]     base_msr
);
    logic [DATA_W-1:0] lvt_word;

    // Entry select for the local vector table; out-of-range reads as 0.
    always_comb begin
        lvt_word = '0;
        for (int k = 0; k < LVT_N; k++)
            if (idx == IDX_W'(k)) lvt_word = lvt_q[k*DATA_W +: DATA_W];
    end

    // Base register image: fixed base, stored flags at bits 8 and 11.
    assign base_msr = {{DATA_W{1'b0}}, WIN_BASE[DATA_W-1:12], en_q, 2'b00, boot_q, 8'h00};

    // Word mux by register select.
    always_comb begin
        case (sel)
            SEL_ID:    rd_data = id_q;
            SEL_VER:   rd_data = RST_VER;
            SEL_TPR:   rd_data = tpr_q;
            SEL_LDR:   rd_data = ldr_q;
            SEL_DFR:   rd_data = dfr_q;
            SEL_SPUR:  rd_data = spur_q;
            SEL_ESR:   rd_data = esr_q;
            SEL_ISR:   rd_data = isr_in[int'(idx)*DATA_W +: DATA_W];
            SEL_TRG:   rd_data = trig_in[int'(idx)*DATA_W +: DATA_W];
            SEL_IRR:   rd_data = irr_in[int'(idx)*DATA_W +: DATA_W];
            SEL_IEN:   rd_data = ien_q[int'(idx)*DATA_W +: DATA_W];
            SEL_LVT:   rd_data = lvt_word;
            SEL_TINIT: rd_data = tinit_q;
            SEL_TCUR:  rd_data = tcur_q;
            SEL_TDIV:  rd_data = tdiv_q;
            default:   rd_data = '0;
        endcase
    end
endmodule

// File: rtl/lic_regbank.sv
// Top of the register bank: qualifies each request by length, global enable
// and access class, commits writes on the request edge and registers the
// response for the following cycle. Assumes one request per cycle at most.
module lic_regbank
    import lic_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic                    req_write,
    input  logic [ADDR_W-1:0]       req_addr,
    input  logic [2:0]              req_len,
    input  logic [DATA_W-1:0]       req_wdata,
    input  logic                    base_wr,
    input  logic                    base_wr_boot,
    input  logic                    base_wr_en,
    input  logic [NUM_VEC-1:0]      isr_in,
    input  logic [NUM_VEC-1:0]      trig_in,
    input  logic [NUM_VEC-1:0]      irr_in,
    output logic                    rsp_valid,
    output logic                    rsp_err,
    output logic [DATA_W-1:0]       rsp_rdata,
    output logic [2*DATA_W-1:0]     base_msr,
    output logic [DATA_W-1:0]       local_id,
    output logic [DATA_W-1:0]       task_prio,
    output logic [DATA_W-1:0]       spurious,
    output logic [LVT_N*DATA_W-1:0] lvt_flat,
    output logic [DATA_W-1:0]       tmr_init,
    output logic [DATA_W-1:0]       tmr_cur,
    output logic [DATA_W-1:0]       tmr_div,
    output logic [NUM_VEC-1:0]      irq_enable
);
    localparam logic [2:0] WORD_LEN = 3'(DATA_W / 8);

    sel_e              sel;
    logic [IDX_W-1:0]  idx;
    logic              rd_ok, wr_ok, acc_ok, wr_fire;
    logic              boot_q, en_q;
    logic [DATA_W-1:0] ldr_q, dfr_q, esr_q, rd_data;

    lic_decode u_dec (.addr(req_addr), .sel(sel), .idx(idx), .rd_ok(rd_ok), .wr_ok(wr_ok));

    // Legal access: right length, enabled, permitted for its direction.
    assign acc_ok  = req_valid && en_q && (req_len == WORD_LEN) && (req_write ? wr_ok : rd_ok);
    assign wr_fire = acc_ok && req_write;

    lic_store u_store (
        .clk(clk), .rst_n(rst_n), .wr_fire(wr_fire), .sel(sel), .idx(idx),
        .wdata(req_wdata), .base_wr(base_wr), .base_wr_boot(base_wr_boot),
        .base_wr_en(base_wr_en), .boot_q(boot_q), .en_q(en_q),
        .id_q(local_id), .tpr_q(task_prio), .ldr_q(ldr_q), .dfr_q(dfr_q),
        .spur_q(spurious), .esr_q(esr_q), .tinit_q(tmr_init), .tcur_q(tmr_cur),
        .tdiv_q(tmr_div), .lvt_q(lvt_flat), .ien_q(irq_enable)
    );

    lic_rdmux u_rd (
        .sel(sel), .idx(idx), .boot_q(boot_q), .en_q(en_q),
        .id_q(local_id), .tpr_q(task_prio), .ldr_q(ldr_q), .dfr_q(dfr_q),
        .spur_q(spurious), .esr_q(esr_q), .tinit_q(tmr_init), .tcur_q(tmr_cur),
        .tdiv_q(tmr_div), .lvt_q(lvt_flat), .ien_q(irq_enable),
        .isr_in(isr_in), .trig_in(trig_in), .irr_in(irr_in),
        .rd_data(rd_data), .base_msr(base_msr)
    );

    // Registered response, one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_err   <= req_valid && !acc_ok;
            rsp_rdata <= (acc_ok && !req_write) ? rd_data : '0;
        end
    end

    // R2: a response follows each request, and only a request.
    a_r2_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    a_r2_no_stray_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    // R3: wrong length errors and leaves the enable mask alone.
    a_r3_len_err: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_len != WORD_LEN) |=> (rsp_err && $stable(irq_enable) && $stable(task_prio)));
    // R4: a cleared enable flag rejects every request.
    a_r4_disabled_err: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !base_msr[11]) |=> rsp_err);
    // R5: a write to the version register errors.
    a_r5_ver_write_err: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_addr == 12'h030) |=> rsp_err);
    // R6: error responses carry no data.
    a_r6_err_zero_data: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (rsp_rdata == '0 && rsp_valid));
endmodule

// File: tb/lic_regbank_bench.sv
`timescale 1ns/1ps
module lic_regbank_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0, req_write = 1'b0;
    logic [11:0]  req_addr = '0;
    logic [2:0]   req_len = 3'd4;
    logic [31:0]  req_wdata = '0;
    logic         base_wr = 1'b0, base_wr_boot = 1'b0, base_wr_en = 1'b0;
    logic [255:0] isr_in = '0, trig_in = '0, irr_in = '0;
    logic         rsp_valid, rsp_err;
    logic [31:0]  rsp_rdata, local_id, task_prio, spurious, tmr_init, tmr_cur, tmr_div;
    logic [63:0]  base_msr;
    logic [191:0] lvt_flat;
    logic [255:0] irq_enable;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    lic_regbank u_lic_regbank (.*);

    task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic acc(input logic w, input logic [11:0] a, input logic [2:0] l,
                       input logic [31:0] d, output logic e, output logic [31:0] q);
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_addr = a; req_len = l; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        e = rsp_err;
        q = rsp_rdata;
    endtask

    task automatic wr_ok(input string rq, input logic [11:0] a, input logic [31:0] d);
        logic e; logic [31:0] q;
        acc(1'b1, a, 3'd4, d, e, q);
        chk({rq, " write ok"}, {63'd0, e}, 64'd0);
    endtask

    task automatic rd_exp(input string rq, input logic [11:0] a, input logic [31:0] exp);
        logic e; logic [31:0] q;
        acc(1'b0, a, 3'd4, 32'h0, e, q);
        chk({rq, " read err"}, {63'd0, e}, 64'd0);
        chk({rq, " read data"}, {32'd0, q}, {32'd0, exp});
    endtask

    task automatic expect_err(input string rq, input logic w, input logic [11:0] a,
                              input logic [2:0] l, input logic [31:0] d);
        logic e; logic [31:0] q;
        acc(w, a, l, d, e, q);
        chk({rq, " error flag"}, {63'd0, e}, 64'd1);
        chk({rq, " error data zero"}, {32'd0, q}, 64'd0);
    endtask

    task automatic t_reset;
        chk("R1 base_msr", base_msr, 64'h0000_0000_FEE0_0900);
        chk("R2 idle rsp_valid", {63'd0, rsp_valid}, 64'd0);
        rd_exp("R1 id", 12'h020, 32'h0);
        rd_exp("R1 version", 12'h030, 32'h8005_0010);
        rd_exp("R1 dest format", 12'h0E0, 32'hFFFF_FFFF);
        rd_exp("R1 spurious", 12'h0F0, 32'h0000_00FF);
        rd_exp("R1 task prio", 12'h080, 32'h0);
        for (int k = 0; k < 6; k++)
            chk("R1 lvt entry", {32'd0, lvt_flat[k*32 +: 32]}, 64'h0001_0000);
        rd_exp("R1 lvt error", 12'h370, 32'h0001_0000);
        chk("R1 enable mask", {63'd0, &irq_enable}, 64'd1);
        rd_exp("R1 enable word7", 12'h4F0, 32'hFFFF_FFFF);
        chk("R1 timer init", {32'd0, tmr_init}, 64'd0);
    endtask

    task automatic t_rw;
        wr_ok("R7 id", 12'h020, 32'h0300_0000);
        rd_exp("R2 R7 id back-to-back", 12'h020, 32'h0300_0000);
        chk("R7 local_id port", {32'd0, local_id}, 64'h0300_0000);
        wr_ok("R7 tpr", 12'h080, 32'h0000_0050);
        chk("R7 task_prio port", {32'd0, task_prio}, 64'h50);
        wr_ok("R7 ldr", 12'h0D0, 32'hA5A5_0000);
        rd_exp("R7 ldr", 12'h0D0, 32'hA5A5_0000);
        wr_ok("R7 dfr", 12'h0E0, 32'h0FFF_FFFF);
        rd_exp("R7 dfr", 12'h0E0, 32'h0FFF_FFFF);
        wr_ok("R7 spur", 12'h0F0, 32'h0000_01EF);
        chk("R7 spurious port", {32'd0, spurious}, 64'h1EF);
        wr_ok("R7 esr", 12'h280, 32'h0000_0040);
        rd_exp("R7 esr", 12'h280, 32'h0000_0040);
        wr_ok("R7 div", 12'h3E0, 32'h0000_000B);
        chk("R7 tmr_div port", {32'd0, tmr_div}, 64'hB);
        for (int k = 0; k < 6; k++)
            wr_ok("R7 lvt", 12'h320 + 12'(k * 16), 32'h0000_0040 + 32'(k));
        for (int k = 0; k < 6; k++)
            chk("R7 lvt_flat slice", {32'd0, lvt_flat[k*32 +: 32]}, 64'h40 + 64'(k));
        rd_exp("R7 lvt lint0", 12'h350, 32'h0000_0043);
    endtask

    task automatic t_ro;
        expect_err("R5 version write", 1'b1, 12'h030, 3'd4, 32'h1234);
        rd_exp("R5 version kept", 12'h030, 32'h8005_0010);
        expect_err("R5 apr write", 1'b1, 12'h090, 3'd4, 32'h1);
        rd_exp("R5 apr zero", 12'h090, 32'h0);
        expect_err("R5 ppr write", 1'b1, 12'h0A0, 3'd4, 32'h1);
        rd_exp("R5 ppr zero", 12'h0A0, 32'h0);
        expect_err("R5 remote read write", 1'b1, 12'h0C0, 3'd4, 32'h1);
        rd_exp("R5 icmd lo zero", 12'h300, 32'h0);
        expect_err("R5 icmd hi write", 1'b1, 12'h310, 3'd4, 32'h1);
        expect_err("R5 isr write", 1'b1, 12'h130, 3'd4, 32'h1);
        expect_err("R5 trig write", 1'b1, 12'h1F0, 3'd4, 32'h1);
        expect_err("R5 irr write", 1'b1, 12'h200, 3'd4, 32'h1);
        expect_err("R5 feature write", 1'b1, 12'h400, 3'd4, 32'h1);
    endtask

    task automatic t_unhandled;
        expect_err("R6 eoi read", 1'b0, 12'h0B0, 3'd4, 32'h0);
        expect_err("R6 eoi write", 1'b1, 12'h0B0, 3'd4, 32'h0);
        expect_err("R6 feature read", 1'b0, 12'h400, 3'd4, 32'h0);
        expect_err("R6 ext cmd read", 1'b0, 12'h410, 3'd4, 32'h0);
        expect_err("R6 seoi write", 1'b1, 12'h420, 3'd4, 32'h0);
        expect_err("R6 ext lvt read", 1'b0, 12'h530, 3'd4, 32'h0);
        expect_err("R6 undecoded", 1'b0, 12'h5F0, 3'd4, 32'h0);
        expect_err("R6 unaligned", 1'b1, 12'h084, 3'd4, 32'h77);
        rd_exp("R6 tpr untouched", 12'h080, 32'h0000_0050);
    endtask

    task automatic t_len;
        expect_err("R3 short read", 1'b0, 12'h020, 3'd2, 32'h0);
        expect_err("R3 short write", 1'b1, 12'h080, 3'd1, 32'hFF);
        rd_exp("R3 tpr unchanged", 12'h080, 32'h0000_0050);
        expect_err("R3 wide mask write", 1'b1, 12'h480, 3'd0, 32'h0);
        chk("R3 mask unchanged", {32'd0, irq_enable[31:0]}, 64'hFFFF_FFFF);
    endtask

    task automatic t_arrays;
        for (int k = 0; k < 8; k++) begin
            isr_in[k*32 +: 32]  = 32'h1100_0000 + 32'(k);
            trig_in[k*32 +: 32] = 32'h2200_0000 + 32'(k);
            irr_in[k*32 +: 32]  = 32'h3300_0000 + 32'(k);
        end
        rd_exp("R8 isr word0", 12'h100, 32'h1100_0000);
        rd_exp("R8 isr word5", 12'h150, 32'h1100_0005);
        rd_exp("R8 trig word7", 12'h1F0, 32'h2200_0007);
        rd_exp("R8 irr word2", 12'h220, 32'h3300_0002);
    endtask

    task automatic t_mask;
        wr_ok("R9 mask word3", 12'h4B0, 32'h0F0F_0000);
        chk("R9 irq_enable word3", {32'd0, irq_enable[127:96]}, 64'h0F0F_0000);
        chk("R9 irq_enable word2", {32'd0, irq_enable[95:64]}, 64'hFFFF_FFFF);
        rd_exp("R9 mask word3", 12'h4B0, 32'h0F0F_0000);
    endtask

    task automatic t_timer;
        wr_ok("R10 init", 12'h380, 32'h0000_1000);
        chk("R10 tmr_init", {32'd0, tmr_init}, 64'h1000);
        chk("R10 tmr_cur loaded", {32'd0, tmr_cur}, 64'h1000);
        wr_ok("R10 cur", 12'h390, 32'h0000_0020);
        chk("R10 tmr_init kept", {32'd0, tmr_init}, 64'h1000);
        rd_exp("R10 cur readback", 12'h390, 32'h0000_0020);
    endtask

    task automatic t_disable;
        @(negedge clk); base_wr = 1'b1; base_wr_boot = 1'b0; base_wr_en = 1'b0;
        @(negedge clk); base_wr = 1'b0;
        chk("R4 msr after clear", base_msr, 64'h0000_0000_FEE0_0000);
        expect_err("R4 read while disabled", 1'b0, 12'h020, 3'd4, 32'h0);
        expect_err("R4 write while disabled", 1'b1, 12'h080, 3'd4, 32'h99);
        chk("R4 tpr unchanged", {32'd0, task_prio}, 64'h50);
        @(negedge clk); base_wr = 1'b1; base_wr_boot = 1'b1; base_wr_en = 1'b1;
        @(negedge clk); base_wr = 1'b0;
        chk("R4 msr restored", base_msr, 64'h0000_0000_FEE0_0900);
    endtask

    task automatic t_collide;
        logic e; logic [31:0] q;
        @(negedge clk);
        base_wr = 1'b1; base_wr_boot = 1'b1; base_wr_en = 1'b0;
        req_valid = 1'b1; req_write = 1'b0; req_addr = 12'h020; req_len = 3'd4;
        @(negedge clk);
        base_wr = 1'b0; req_valid = 1'b0;
        chk("R11 access with clearing write ok", {63'd0, rsp_err}, 64'd0);
        chk("R11 access with clearing write data", {32'd0, rsp_rdata}, 64'h0300_0000);
        expect_err("R11 next access disabled", 1'b0, 12'h020, 3'd4, 32'h0);
        @(negedge clk);
        base_wr = 1'b1; base_wr_boot = 1'b1; base_wr_en = 1'b1;
        req_valid = 1'b1; req_write = 1'b0; req_addr = 12'h020; req_len = 3'd4;
        @(negedge clk);
        base_wr = 1'b0; req_valid = 1'b0;
        chk("R11 access with setting write errs", {63'd0, rsp_err}, 64'd1);
        acc(1'b0, 12'h020, 3'd4, 32'h0, e, q);
        chk("R11 next access enabled", {63'd0, e}, 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_rw();
        t_ro();
        t_unhandled();
        t_len();
        t_arrays();
        t_mask();
        t_timer();
        t_disable();
        t_collide();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule